// File: doc/BRIEF.md
# Synchronized External-Clock Period Timer

This block is a 16-bit timer that counts falling edges on an asynchronous external clock pin. It can also count once per instruction cycle from the oscillator. The oscillator is divided into a repeating four-phase instruction cycle, Q1 to Q4. The external pin goes through a synchronizer and is looked at only in phases Q2 and Q4. Because of this, the time from a pin edge to the count changing is bounded and does not depend on when the edge arrives.

The count is compared with a 16-bit period value. When the count equals the period, the next increment returns it to zero and raises a sticky interrupt flag. A host with an 8-bit data path reads and writes the count and the period one byte at a time, through a small address-decoded register file. It also controls an enable bit and a clock-source bit, and it clears the flag.

Top module: `ext_period_timer`

## Requirements
- R1: With the source bit (control bit 1) set to 1 and the enable bit (control bit 0) set, every falling edge on `ext_clk` that is seen by the sampling adds one to the count. Nothing else changes the count apart from a wrap or a host write.
- R2: The pin is looked at only in phases Q2 and Q4 of a four-phase cycle driven by the oscillator, so two samples are always two oscillator periods apart. A low level that lasts at least three oscillator periods, after a long high level, is always counted.
- R3: A falling edge on the pin changes the count between 2 and 6 oscillator periods after the edge.
- R4: When an increment happens while the count equals the period, the count becomes 0x0000 and the flag is set. This holds for a period of 0x0000 as well, where every increment leaves the count at zero and sets the flag.
- R5: While the enable bit is 0, the count keeps its value whatever the pin or the cycle does.
- R6: Count low, count high, period low and period high are at addresses 0, 1, 2 and 3 and read back what was written. A count-byte write takes priority over an increment in the same cycle and throws away a pending detected edge.
- R7: The flag (control bit 2) stays set until the host writes the control register with bit 2 equal to 0. Writing 1 to bit 2 leaves the flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: With the source bit set to 0 and the enable bit set, the count advances once every four oscillator periods.
- R9: After reset the count is 0x0000, the period is 0xFFFF, the flag is 0, and the enable and source bits are 0.
- R10: The control register is at address 4 and reads {5'b0, flag, source, enable}. Addresses 5 to 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Asynchronous external count input |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| irq_flag | output | 1 | Sticky period-match flag |

## Verification
The assertions take the pin to be truly asynchronous. They make no claim about when a given edge is counted; they check only how each count change relates to the increment and write qualifiers. They also assume the host raises the write strobe for exactly one cycle per access, with a stable address and data. The stimulus holds each pin level for at least three oscillator periods, so every edge is seen once. It performs all bus accesses at the falling clock edge with one-cycle strobes, so no count update depends on a half-seen pin level.

// File: rtl/ept_pkg.sv
package ept_pkg;
   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_SRC_BIT  = 1;
   localparam int CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/ept_phase_gen.sv
module ept_phase_gen
   import ept_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_e phase,
   output logic   sample_en,
   output logic   cycle_end
);
   phase_e ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_Q1;
      else        ph_q <= phase_e'(ph_q + 2'd1);
   end

   assign phase     = ph_q;
   assign sample_en = (ph_q == PH_Q2) || (ph_q == PH_Q4);
   assign cycle_end = (ph_q == PH_Q4);
endmodule

// File: rtl/ept_edge_sync.sv
module ept_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic sample_en,
   input  logic flush,
   output logic fall_pulse
);
   logic [STAGES-1:0] chain;
   logic              synced;
   logic              prev_q;
   logic              fall_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("ept_edge_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign synced = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         if (sample_en) prev_q <= synced;
         fall_q <= sample_en & prev_q & ~synced & ~flush;
      end
   end

   assign fall_pulse = fall_q & ~flush;
endmodule

// File: rtl/ept_count_core.sv
module ept_count_core #(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   localparam int NBYTES = CNT_W / BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [NBYTES-1:0] byte_wr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  count,
   output logic              wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             any_wr;
   logic             at_period;

   assign any_wr    = |byte_wr;
   assign at_period = (cnt_q == period);
   assign wrap      = tick & ~any_wr & at_period;

   always_comb begin
      cnt_d = cnt_q;
      if (any_wr) begin
         for (int b = 0; b < NBYTES; b++) begin
            if (byte_wr[b]) cnt_d[b*BUS_W +: BUS_W] = wdata;
         end
      end else if (tick) begin
         cnt_d = at_period ? '0 : cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = cnt_q;
endmodule

// File: rtl/ext_period_timer.sv
module ext_period_timer
   import ept_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_clk,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_flag
);
   localparam int NBYTES    = CNT_W / BUS_W;
   localparam int PER_BASE  = NBYTES;
   localparam int CTRL_ADDR = 2 * NBYTES;

   if (CNT_W != NBYTES * BUS_W) begin : g_bad_width
      $error("ext_period_timer: CNT_W must be a whole number of bus bytes");
   end
   if ((1 << ADDR_W) <= CTRL_ADDR) begin : g_bad_addr
      $error("ext_period_timer: ADDR_W too narrow for the register map");
   end
   if (BUS_W < 3) begin : g_bad_bus
      $error("ext_period_timer: BUS_W must hold the control bits");
   end

   phase_e             phase;
   logic               sample_en;
   logic               cycle_end;
   logic               fall_pulse;
   logic               tick;
   logic [NBYTES-1:0]  cnt_wr;
   logic [NBYTES-1:0]  per_wr;
   logic               ctrl_wr;
   logic               flag_clr;
   logic               wrap;
   logic [CNT_W-1:0]   count_q;
   logic [CNT_W-1:0]   period_q;
   logic               en_q;
   logic               src_q;
   logic               flag_q;

   for (genvar b = 0; b < NBYTES; b++) begin : g_dec
      assign cnt_wr[b] = bus_wr && (bus_addr == ADDR_W'(b));
      assign per_wr[b] = bus_wr && (bus_addr == ADDR_W'(PER_BASE + b));
   end
   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign flag_clr = ctrl_wr && !bus_wdata[CTRL_FLAG_BIT];

   ept_phase_gen u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .sample_en (sample_en),
      .cycle_end (cycle_end)
   );

   ept_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (ext_clk),
      .sample_en  (sample_en),
      .flush      (|cnt_wr),
      .fall_pulse (fall_pulse)
   );

   assign tick = en_q & (src_q ? fall_pulse : cycle_end);

   ept_count_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .byte_wr (cnt_wr),
      .wdata   (bus_wdata),
      .period  (period_q),
      .count   (count_q),
      .wrap    (wrap)
   );

   for (genvar b = 0; b < NBYTES; b++) begin : g_per
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         period_q[b*BUS_W +: BUS_W] <= '1;
         else if (per_wr[b]) period_q[b*BUS_W +: BUS_W] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         src_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q  <= bus_wdata[CTRL_EN_BIT];
            src_q <= bus_wdata[CTRL_SRC_BIT];
         end
         if (wrap)          flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NBYTES; b++) begin
         if (bus_addr == ADDR_W'(b))            bus_rdata = count_q[b*BUS_W +: BUS_W];
         if (bus_addr == ADDR_W'(PER_BASE + b)) bus_rdata = period_q[b*BUS_W +: BUS_W];
      end
      if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata[CTRL_EN_BIT]   = en_q;
         bus_rdata[CTRL_SRC_BIT]  = src_q;
         bus_rdata[CTRL_FLAG_BIT] = flag_q;
      end
   end

   assign irq_flag = flag_q;
endmodule

// File: rtl/ept_timer_chk.sv
module ept_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int NBYTES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_en,
   input logic              tick,
   input logic [NBYTES-1:0] cnt_wr,
   input logic [BUS_W-1:0]  wdata,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  period,
   input logic              en,
   input logic              flag,
   input logic              flag_clr,
   input logic              wrap
);
   p_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|cnt_wr) && !tick) |=> $stable(count));

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(|cnt_wr) && count != period) |=> count == CNT_W'($past(count) + CNT_W'(1)));

   p_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> !sample_en);

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(|cnt_wr) && count == period) |=> (count == '0 && flag));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !(|cnt_wr)) |=> $stable(count));

   p_wrlo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr[0] |=> count[BUS_W-1:0] == $past(wdata));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

   p_setwins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag);
endmodule

bind ext_period_timer ept_timer_chk #(
   .CNT_W (CNT_W),
   .BUS_W (BUS_W),
   .NBYTES(NBYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sample_en (sample_en),
   .tick      (tick),
   .cnt_wr    (cnt_wr),
   .wdata     (bus_wdata),
   .count     (count_q),
   .period    (period_q),
   .en        (en_q),
   .flag      (flag_q),
   .flag_clr  (flag_clr),
   .wrap      (wrap)
);

// File: tb/ext_period_timer_bench.sv
module ext_period_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_clk = 1'b1;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_flag;

   int n_vec = 0;
   int n_err = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_period_timer u_ext_period_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_clk   (ext_clk),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_flag  (irq_flag)
   );

   function automatic void chk(string tag, int actual, int expected);
      n_vec++;
      if (actual != expected) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
      end
   endfunction

   // monitor: compares queued expectations against read data
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, int'(bus_rdata), int'(e));
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wr    = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
   endtask

   task automatic pulses(input int n, input int low_len);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_clk = 1'b0;
         repeat (low_len) @(negedge clk);
         ext_clk = 1'b1;
         repeat (4) @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R9 reset state
      expect_rd(3'd0, 8'h00, "R9 count lo");
      expect_rd(3'd1, 8'h00, "R9 count hi");
      expect_rd(3'd2, 8'hFF, "R9 period lo");
      expect_rd(3'd3, 8'hFF, "R9 period hi");
      expect_rd(3'd4, 8'h00, "R9 ctrl");
      chk("R9 irq pin", int'(irq_flag), 0);

      // R10 unused address
      expect_rd(3'd5, 8'h00, "R10 unused addr");

      // R6 byte access
      wr(3'd0, 8'h34);
      wr(3'd1, 8'h12);
      wr(3'd2, 8'hA5);
      wr(3'd3, 8'h5A);
      expect_rd(3'd0, 8'h34, "R6 count lo readback");
      expect_rd(3'd1, 8'h12, "R6 count hi readback");
      expect_rd(3'd2, 8'hA5, "R6 period lo readback");
      expect_rd(3'd3, 8'h5A, "R6 period hi readback");

      // R5 disabled external source holds
      wr(3'd4, 8'h02);
      expect_rd(3'd4, 8'h02, "R10 ctrl source bit");
      pulses(3, 4);
      expect_rd(3'd0, 8'h34, "R5 held lo");
      expect_rd(3'd1, 8'h12, "R5 held hi");

      // R1 external counting
      wr(3'd2, 8'hFF);
      wr(3'd3, 8'hFF);
      wr(3'd4, 8'h03);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      pulses(5, 4);
      expect_rd(3'd0, 8'h05, "R1 five edges");
      expect_rd(3'd1, 8'h00, "R1 high byte");

      // R2 short low levels of three periods are still counted
      pulses(4, 3);
      expect_rd(3'd0, 8'h09, "R2 three-cycle lows counted");

      // R3 latency from pin fall to count change
      @(negedge clk);
      bus_addr = 3'd0;
      ext_clk  = 1'b0;
      begin
         int n;
         n = 0;
         for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            #1;
            n++;
            if (bus_rdata != 8'h09) break;
         end
         n_vec++;
         if (n < 2 || n > 6) begin
            n_err++;
            $display("FAIL R3 latency actual=%0d expected=2..6", n);
         end
      end
      repeat (4) @(negedge clk);
      ext_clk = 1'b1;
      repeat (8) @(negedge clk);
      expect_rd(3'd0, 8'h0A, "R3 single increment");

      // R4 period wrap and flag
      wr(3'd2, 8'h05);
      wr(3'd3, 8'h00);
      wr(3'd0, 8'h00);
      pulses(8, 4);
      expect_rd(3'd0, 8'h02, "R4 wrapped count");
      expect_rd(3'd4, 8'h07, "R4 flag set");
      chk("R4 irq pin", int'(irq_flag), 1);

      // R7 sticky flag and clear
      wr(3'd4, 8'h07);
      expect_rd(3'd4, 8'h07, "R7 write one keeps flag");
      wr(3'd4, 8'h03);
      expect_rd(3'd4, 8'h03, "R7 write zero clears flag");
      chk("R7 irq pin cleared", int'(irq_flag), 0);

      // R4 period zero boundary
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h00);
      pulses(2, 4);
      expect_rd(3'd0, 8'h00, "R4 period zero count");
      expect_rd(3'd4, 8'h07, "R4 period zero flag");

      // R8 internal source: one step per four cycles
      wr(3'd4, 8'h00);
      wr(3'd2, 8'hFF);
      wr(3'd3, 8'hFF);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd4, 8'h01);
      repeat (3) @(negedge clk);
      bus_addr = 3'd0;
      begin
         logic [7:0] a;
         logic [7:0] b;
         @(posedge clk); #1; a = bus_rdata;
         repeat (8) @(posedge clk);
         #1; b = bus_rdata;
         chk("R8 steps in eight cycles", int'(b - a), 2);
         repeat (16) @(posedge clk);
         #1;
         chk("R8 steps in twenty-four cycles", int'(bus_rdata - a), 6);
      end

      // R5 disable freezes internal counting
      wr(3'd4, 8'h00);
      @(negedge clk);
      bus_addr = 3'd0;
      begin
         logic [7:0] h;
         @(posedge clk); #1; h = bus_rdata;
         repeat (20) @(posedge clk);
         #1;
         chk("R5 internal hold", int'(bus_rdata), int'(h));
      end

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule